// File: doc/BRIEF.md
# Pipelined Conversion Sequencer

This block is the timing and control core of a pipelined sampling converter, seen from the digital side. A start request reaches it asynchronously. The block synchronises the request, acts only on its rising edge, raises a busy flag for a fixed number of clock cycles, and latches the raw sample word from a parallel bus. When the conversion completes, the word is stored for the result pipeline.

The result pipeline has three stages and is clocked by start edges, not by the system clock. The word from conversion k therefore reaches the output after the start pulse of conversion k+3. Each word carries a valid tag.

A start edge that arrives while a conversion is still busy restarts the timer. It also poisons two results: the interrupted one and the one that replaces it. Two sticky monitors report misuse:
- start pulses whose high or low time falls outside the allowed windows;
- output-control inputs that change while a conversion is busy.

Top module: `conv_seq`

## Requirements
- R1: Only a rising edge of the synchronised `start_cv` starts a conversion. Holding it high, or letting it fall, starts nothing further.
- R2: While `rst` is high, the next clock edge clears `conv_busy`, `res_valid`, `width_err` and `proto_err`.
- R3: `conv_busy` rises on the third clock edge that samples `start_cv` high (two synchroniser flops and one timer flop). It then stays high for exactly BUSY_CYC cycles (default 30).
- R4: After the k-th start pulse, `res_data` shows the `smp_in` word captured at the start edge of conversion k-3, with `res_valid`=1. After reset, the first three pulses yield `res_valid`=0, so the first valid word appears after the fourth pulse.
- R5: A start edge while `conv_busy` is high begins a new conversion. Both the interrupted conversion and the new one then reach the output with `res_valid`=0.
- R6: A start high time of H cycles is accepted when H is in 4..17 or 28..46 (defaults). Any other H sets `width_err`.
- R7: A high time above 46 cycles is accepted only when the low time before it was at least SLOW_LO cycles (default 60). Otherwise it sets `width_err`.
- R8: A low time of fewer than 4 cycles between two start pulses sets `width_err`. The first rise after reset is exempt.
- R9: A change of `out_en`, `code_inv` or `buf_rd` while `conv_busy` is high sets `proto_err`. Changes while idle leave `proto_err` at 0. Both flags stay set until reset.
- R10: `res_data` and `res_valid` change only in response to a start edge. They hold their values through any idle time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cv | input | 1 | Asynchronous start-convert request |
| smp_in | input | 16 | Raw sample word, latched at the start edge |
| out_en | input | 1 | Output-enable control (monitored) |
| code_inv | input | 1 | Code complement select (monitored) |
| buf_rd | input | 1 | Buffer read strobe (monitored) |
| conv_busy | output | 1 | High while a conversion is in progress |
| res_data | output | 16 | Pipelined result word |
| res_valid | output | 1 | Valid tag of `res_data` |
| width_err | output | 1 | Sticky start-pulse width violation |
| proto_err | output | 1 | Sticky control-change-while-busy violation |

## Verification
The assertions assume that `start_cv` is a level that stays put for at least one clock. They also assume that `smp_in` is steady during the first three clocks of each start pulse, so that the latched word is well defined.

The stimulus drives every input on the falling clock edge and builds start pulses from whole cycle counts. It keeps `smp_in` constant until the next pulse. It moves the control inputs while busy only in the one case meant to provoke `proto_err`.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

    localparam int unsigned SMP_W = 16;

    typedef struct packed {
        logic             valid;
        logic [SMP_W-1:0] data;
    } slot_t;

    typedef enum logic {
        TM_IDLE = 1'b0,
        TM_BUSY = 1'b1
    } tm_state_e;

    function automatic logic in_range(input int unsigned v,
                                      input int unsigned lo,
                                      input int unsigned hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/cseq_start_sync.sv
module cseq_start_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_async,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   dly_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[0] <= 1'b0;
                else     chain_q[0] <= start_async;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= 1'b0;
                else     chain_q[g] <= chain_q[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dly_q <= 1'b0;
        else     dly_q <= chain_q[SYNC_STAGES-1];
    end

    assign lvl  = chain_q[SYNC_STAGES-1];
    assign rise = lvl & ~dly_q;
    assign fall = ~lvl & dly_q;
endmodule

// File: rtl/cseq_width_chk.sv
module cseq_width_chk
    import cseq_pkg::*;
#(
    parameter int unsigned HI_A_MIN = 4,
    parameter int unsigned HI_A_MAX = 17,
    parameter int unsigned HI_B_MIN = 28,
    parameter int unsigned HI_B_MAX = 46,
    parameter int unsigned LO_MIN   = 4,
    parameter int unsigned SLOW_LO  = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic fall,
    output logic width_err
);
    localparam int unsigned CW = $clog2(SLOW_LO + HI_B_MAX + 2);

    logic [CW-1:0] run_q;
    logic [CW-1:0] prev_lo_q;
    logic          first_q;
    logic          err_q;
    logic          hi_ok;

    // Length of the level that is ending is held in run_q at each transition.
    always_comb begin
        hi_ok = in_range(32'(run_q), HI_A_MIN, HI_A_MAX)
              | in_range(32'(run_q), HI_B_MIN, HI_B_MAX)
              | ((32'(run_q) > HI_B_MAX) && (32'(prev_lo_q) >= SLOW_LO));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= '0;
            prev_lo_q <= '0;
            first_q   <= 1'b1;
            err_q     <= 1'b0;
        end else begin
            if (rise || fall)     run_q <= CW'(1);
            else if (run_q != '1) run_q <= run_q + CW'(1);

            if (rise) begin
                first_q   <= 1'b0;
                prev_lo_q <= run_q;
                if (!first_q && (32'(run_q) < LO_MIN)) err_q <= 1'b1;
            end
            if (fall && !hi_ok) err_q <= 1'b1;
        end
    end

    assign width_err = err_q;
endmodule

// File: rtl/cseq_timer.sv
module cseq_timer
    import cseq_pkg::*;
#(
    parameter int unsigned BUSY_CYC = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic [SMP_W-1:0] smp_in,
    output logic             busy,
    output logic             restart,
    output slot_t            done_slot
);
    localparam int unsigned CNT_W = $clog2(BUSY_CYC);

    tm_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SMP_W-1:0] hold_q;
    logic             poison_q;
    slot_t            done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= TM_IDLE;
            cnt_q    <= '0;
            hold_q   <= '0;
            poison_q <= 1'b0;
            done_q   <= '0;
        end else if (rise) begin
            state_q  <= TM_BUSY;
            cnt_q    <= '0;
            hold_q   <= smp_in;
            poison_q <= (state_q == TM_BUSY);
        end else if (state_q == TM_BUSY) begin
            if (cnt_q == CNT_W'(BUSY_CYC - 1)) begin
                state_q      <= TM_IDLE;
                done_q.valid <= ~poison_q;
                done_q.data  <= hold_q;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign busy      = (state_q == TM_BUSY);
    assign restart   = rise && (state_q == TM_BUSY);
    assign done_slot = done_q;
endmodule

// File: rtl/cseq_pipe.sv
module cseq_pipe
    import cseq_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  shift,
    input  slot_t in_slot,
    output slot_t head_slot,
    output slot_t out_slot
);
    slot_t stg_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stg
        always_ff @(posedge clk) begin
            if (rst) begin
                stg_q[g] <= '0;
            end else if (shift) begin
                if (g == 0) stg_q[g] <= in_slot;
                else        stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign head_slot = stg_q[0];
    assign out_slot  = stg_q[DEPTH-1];
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import cseq_pkg::*;
#(
    parameter int unsigned BUSY_CYC    = 30,
    parameter int unsigned PIPE_DEPTH  = 3,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HI_A_MIN    = 4,
    parameter int unsigned HI_A_MAX    = 17,
    parameter int unsigned HI_B_MIN    = 28,
    parameter int unsigned HI_B_MAX    = 46,
    parameter int unsigned LO_MIN      = 4,
    parameter int unsigned SLOW_LO     = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_cv,
    input  logic [SMP_W-1:0] smp_in,
    input  logic             out_en,
    input  logic             code_inv,
    input  logic             buf_rd,
    output logic             conv_busy,
    output logic [SMP_W-1:0] res_data,
    output logic             res_valid,
    output logic             width_err,
    output logic             proto_err
);
    localparam int unsigned CTL_W = 3;

    logic             st_lvl;
    logic             st_rise;
    logic             st_fall;
    logic             restart;
    slot_t            done_slot;
    slot_t            push_slot;
    slot_t            head_slot;
    slot_t            out_slot;
    logic [CTL_W-1:0] ctl_now;
    logic [CTL_W-1:0] ctl_q;
    logic             proto_q;

    cseq_start_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .start_async(start_cv),
        .lvl(st_lvl), .rise(st_rise), .fall(st_fall)
    );

    cseq_width_chk #(
        .HI_A_MIN(HI_A_MIN), .HI_A_MAX(HI_A_MAX),
        .HI_B_MIN(HI_B_MIN), .HI_B_MAX(HI_B_MAX),
        .LO_MIN(LO_MIN), .SLOW_LO(SLOW_LO)
    ) u_width (
        .clk(clk), .rst(rst), .rise(st_rise), .fall(st_fall),
        .width_err(width_err)
    );

    cseq_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
        .clk(clk), .rst(rst), .rise(st_rise), .smp_in(smp_in),
        .busy(conv_busy), .restart(restart), .done_slot(done_slot)
    );

    // A restart inserts the interrupted conversion as a poisoned slot.
    always_comb begin
        push_slot = done_slot;
        if (restart) push_slot.valid = 1'b0;
    end

    cseq_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
        .clk(clk), .rst(rst), .shift(st_rise), .in_slot(push_slot),
        .head_slot(head_slot), .out_slot(out_slot)
    );

    assign ctl_now = {out_en, code_inv, buf_rd};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= ctl_now;
            proto_q <= 1'b0;
        end else begin
            ctl_q <= ctl_now;
            if (conv_busy && (ctl_now != ctl_q)) proto_q <= 1'b1;
        end
    end

    assign proto_err = proto_q;
    assign res_data  = out_slot.data;
    assign res_valid = out_slot.valid;
endmodule

// File: rtl/cseq_chk.sv
module cseq_chk
    import cseq_pkg::*;
#(
    parameter int unsigned BUSY_CYC = 30
) (
    input logic             clk,
    input logic             rst,
    input logic             start_rise,
    input logic             eoc,
    input logic             head_valid,
    input logic [SMP_W-1:0] res_data,
    input logic             res_valid,
    input logic             width_err,
    input logic             proto_err
);
    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)             run_q <= '0;
        else if (start_rise) run_q <= 16'd1;
        else if (eoc)        run_q <= run_q + 16'd1;
        else                 run_q <= '0;
    end

    a_r1_edge_only: assert property (@(posedge clk) disable iff (rst)
        (!start_rise && !eoc) |=> !eoc);

    a_r2_reset_clears: assert property (@(posedge clk)
        rst |=> (!res_valid && !eoc && !width_err && !proto_err));

    a_r3_busy_follows_edge: assert property (@(posedge clk) disable iff (rst)
        start_rise |=> eoc);

    a_r3_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        eoc |-> (run_q <= 16'(BUSY_CYC)));

    a_r3_busy_full_length: assert property (@(posedge clk) disable iff (rst)
        $fell(eoc) |-> (run_q == 16'(BUSY_CYC + 1)));

    a_r5_restart_poisons: assert property (@(posedge clk) disable iff (rst)
        (start_rise && eoc) |=> !head_valid);

    a_r6_width_sticky: assert property (@(posedge clk) disable iff (rst)
        width_err |=> width_err);

    a_r9_proto_sticky: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    a_r10_output_hold: assert property (@(posedge clk) disable iff (rst)
        !start_rise |=> ($stable(res_valid) && $stable(res_data)));
endmodule

bind conv_seq cseq_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
    .clk(clk), .rst(rst), .start_rise(st_rise), .eoc(conv_busy),
    .head_valid(head_slot.valid), .res_data(res_data), .res_valid(res_valid),
    .width_err(width_err), .proto_err(proto_err)
);

// File: tb/conv_seq_bench.sv
module conv_seq_bench;
    localparam int CLK_P = 10;
    localparam int BUSY  = 30;
    localparam int NV    = 9;

    localparam logic [15:0] TBL_SMP [NV] = '{16'h1111, 16'h2222, 16'h3333, 16'h4444,
                                             16'h5555, 16'h6666, 16'h7777, 16'h8888, 16'h9999};
    localparam int          TBL_LO  [NV] = '{40, 40, 10, 40, 40, 40, 40, 40, 40};
    localparam logic        TBL_V   [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic [15:0] TBL_D   [NV] = '{16'h0, 16'h0, 16'h0, 16'h1111,
                                             16'h2222, 16'h0, 16'h0, 16'h5555, 16'h6666};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_cv = 1'b0;
    logic [15:0] smp_in = '0;
    logic        out_en = 1'b0;
    logic        code_inv = 1'b0;
    logic        buf_rd = 1'b0;
    logic        conv_busy;
    logic [15:0] res_data;
    logic        res_valid;
    logic        width_err;
    logic        proto_err;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    conv_seq u_conv_seq (
        .clk(clk), .rst(rst), .start_cv(start_cv), .smp_in(smp_in),
        .out_en(out_en), .code_inv(code_inv), .buf_rd(buf_rd),
        .conv_busy(conv_busy), .res_data(res_data), .res_valid(res_valid),
        .width_err(width_err), .proto_err(proto_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        start_cv = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse(input int hi, input int lo, input logic [15:0] s);
        smp_in = s;
        start_cv = 1'b1;
        repeat (hi) @(negedge clk);
        start_cv = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic width_case(input int hi, input logic exp, input string req);
        do_reset();
        pulse(10, 40, 16'h0);
        pulse(hi, 40, 16'h0);
        chk(req, 32'(width_err), 32'(exp));
    endtask

    task automatic low_case(input int lo, input logic exp);
        do_reset();
        pulse(10, lo, 16'h0);
        pulse(10, 40, 16'h0);
        chk("R8 low width", 32'(width_err), 32'(exp));
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int rises;
        int highs;
        logic prev;
        @(negedge clk);
        do_reset();
        // R2: reset state
        chk("R2 busy", 32'(conv_busy), 32'd0);
        chk("R2 valid", 32'(res_valid), 32'd0);
        chk("R2 width_err", 32'(width_err), 32'd0);
        chk("R2 proto_err", 32'(proto_err), 32'd0);

        // R4 / R5: pipeline latency and restart poisoning
        for (int i = 0; i < NV; i++) begin
            pulse(10, TBL_LO[i], TBL_SMP[i]);
            chk($sformatf("R4 R5 valid after pulse %0d", i + 1), 32'(res_valid), 32'(TBL_V[i]));
            if (TBL_V[i])
                chk($sformatf("R4 data after pulse %0d", i + 1), 32'(res_data), 32'(TBL_D[i]));
        end
        chk("R6 in-window pulses", 32'(width_err), 32'd0);

        // R10: output holds through idle time
        repeat (300) @(negedge clk);
        chk("R10 valid held", 32'(res_valid), 32'd1);
        chk("R10 data held", 32'(res_data), 32'h6666);

        // R2: reset again clears the valid tag
        do_reset();
        chk("R2 valid after rerun reset", 32'(res_valid), 32'd0);

        // R3: busy timing and length
        repeat (5) @(negedge clk);
        start_cv = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R3 busy still low after two edges", 32'(conv_busy), 32'd0);
        @(negedge clk);
        chk("R3 busy high on third edge", 32'(conv_busy), 32'd1);
        highs = 1;
        rises = 1;
        prev = 1'b1;
        // R1: start held high for a long time; one conversion only
        for (int c = 0; c < 120; c++) begin
            @(negedge clk);
            if (conv_busy) highs++;
            if (conv_busy && !prev) rises++;
            prev = conv_busy;
        end
        chk("R3 busy length", 32'(highs), 32'(BUSY));
        chk("R1 held level starts one conversion", 32'(rises), 32'd1);
        start_cv = 1'b0;
        rises = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (conv_busy) rises++;
        end
        chk("R1 falling edge starts nothing", 32'(rises), 32'd0);

        // R6: high-width windows
        width_case(3,  1'b1, "R6 high 3");
        width_case(4,  1'b0, "R6 high 4");
        width_case(17, 1'b0, "R6 high 17");
        width_case(18, 1'b1, "R6 high 18");
        width_case(27, 1'b1, "R6 high 27");
        width_case(28, 1'b0, "R6 high 28");
        width_case(46, 1'b0, "R6 high 46");
        width_case(47, 1'b1, "R7 high 47 at full rate");
        width_case(60, 1'b1, "R7 wide pulse after short low");

        // R7: wide pulse after a long low phase
        do_reset();
        pulse(10, 70, 16'h0);
        pulse(60, 40, 16'h0);
        chk("R7 wide pulse at slow rate", 32'(width_err), 32'd0);

        // R8: low width
        low_case(3, 1'b1);
        low_case(4, 1'b0);

        // R9: control changes while idle vs while busy
        do_reset();
        repeat (5) @(negedge clk);
        out_en = 1'b1;
        buf_rd = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 idle change ignored", 32'(proto_err), 32'd0);
        pulse(10, 40, 16'h0);
        buf_rd = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 change after completion ignored", 32'(proto_err), 32'd0);
        start_cv = 1'b1;
        repeat (6) @(negedge clk);
        code_inv = 1'b1;
        repeat (4) @(negedge clk);
        start_cv = 1'b0;
        repeat (60) @(negedge clk);
        chk("R9 change during busy flagged and held", 32'(proto_err), 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule